// File: doc/BRIEF.md
# External Interrupt Edge Detector

This block watches a single external interrupt pin and latches an interrupt request when the pin makes the transition that software selected. A 3-bit mode register chooses the edge: rising, falling, either, or none. It also chooses the sampling rate. The fast rate is one sample per machine cycle, modelled as every 4th clock. The slow rate is one sample every 64th clock, so a pulse that starts and ends between two slow samples is never seen.

The request flag is sticky. It is set on a recognised edge whatever the enables are, and it stays set until software clears it or the interrupt is acknowledged. The interrupt output is raised only when three things hold at once: the flag is set, the source's own enable is high, and the master enable is high. Enable and disable commands set and clear the master enable. An acknowledge clears both the request flag and the master enable.

A write to the mode register can set the flag spuriously. Software therefore clears the flag after the write. When the slow rate has just been selected, the clear should wait at least 16 machine cycles.

Top module: `extint_edge_unit`

## Requirements
- R1: After reset, `req_o`, `mie_o` and `irq_o` are 0 and the mode is rising edge with fast sampling, so a 0-to-1 pin change sets `req_o` without any mode write.
- R2: Mode bits [1:0] pick the edge: 00 rising, 01 falling, 10 both, 11 none. A 0-to-1 pin change sets the flag only under 00 or 10. A 1-to-0 change sets it only under 01 or 10.
- R3: Mode bit 2 picks the sampling strobe: 0 means every 4th clock edge, 1 means every 64th clock edge. Both strobes count from reset release. An edge is recognised only when two consecutive samples taken on the selected strobe differ, and the pin passes through two synchroniser flops first.
- R4: With bit 2 = 1, a pulse that rises after one slow sample and falls again well before the next slow sample leaves `req_o` at 0.
- R5: Under edge code 11, no pin activity ever sets `req_o`.
- R6: Once set, `req_o` stays 1 regardless of the enables or the pin, until `req_clr_i` or `irq_ack_i` is high at a clock edge. It reads 0 in the following cycle.
- R7: `mie_set_i` sets `mie_o` and `mie_clr_i` clears it from the next cycle. When both are high in the same cycle, the clear wins.
- R8: `irq_o` equals `req_o & src_en_i & mie_o` in every cycle.
- R9: A cycle with `irq_ack_i` high clears both `req_o` and `mie_o` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 1 | Asynchronous external interrupt pin |
| mode_wr_i | input | 1 | Writes `mode_wdata_i` into the mode register |
| mode_wdata_i | input | 3 | Mode value: [1:0] edge code, [2] slow sampling |
| req_clr_i | input | 1 | Clears the request flag |
| mie_set_i | input | 1 | Enable command: sets the master enable |
| mie_clr_i | input | 1 | Disable command: clears the master enable |
| src_en_i | input | 1 | Per-source interrupt enable |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| req_o | output | 1 | Request flag |
| mie_o | output | 1 | Master enable flag |
| irq_o | output | 1 | Vectored interrupt request |

## Verification
The inline assertions check the following on every cycle:
- the flag holds its value when neither a clear nor an acknowledge is present;
- a clear or an acknowledge with no simultaneous edge leaves the flag low;
- a disable command or an acknowledge drops the master enable;
- the flag never rises while the edge code is "none";
- each sampling strobe lasts exactly one cycle.

Only the bench's scenarios can show the rest. That covers the mapping from each edge code and pin transition to a set or unset flag, and the reset default. It also covers the noise rejection of the slow strobe, which depends on where the pulse falls relative to the sampling phase.

// File: rtl/extint_pkg.sv
package extint_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic      slow;
    edge_sel_e sel;
  } mode_t;

  localparam mode_t MODE_RESET = '{slow: 1'b0, sel: EDGE_RISE};

endpackage

// File: rtl/extint_tick_div.sv
module extint_tick_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  generate
    if (DIV > 1) begin : g_pulse_chk
      // R3: a sampling strobe is a single-cycle pulse
      assert_tick_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/extint_edge_det.sv
module extint_edge_det
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_i,
  input  logic      stb_i,
  input  edge_sel_e sel_i,
  output logic      hit_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lvl;
  logic                   samp_q;
  logic                   rise;
  logic                   fall;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin_i;
      end
    end
  endgenerate

  assign lvl = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n)     samp_q <= 1'b0;
    else if (stb_i) samp_q <= lvl;
  end

  assign rise = stb_i &  lvl & ~samp_q;
  assign fall = stb_i & ~lvl &  samp_q;

  always_comb begin
    unique case (sel_i)
      EDGE_RISE: hit_o = rise;
      EDGE_FALL: hit_o = fall;
      EDGE_BOTH: hit_o = rise | fall;
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/extint_req_ctl.sv
module extint_req_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic req_clr_i,
  input  logic mie_set_i,
  input  logic mie_clr_i,
  input  logic irq_ack_i,
  output logic req_o,
  output logic mie_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)                       req_o <= 1'b0;
    else if (hit_i)                   req_o <= 1'b1;
    else if (req_clr_i || irq_ack_i)  req_o <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       mie_o <= 1'b0;
    else if (mie_clr_i || irq_ack_i)  mie_o <= 1'b0;
    else if (mie_set_i)               mie_o <= 1'b1;
  end

  // R6: the flag holds until it is cleared or acknowledged
  assert_req_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !req_clr_i && !irq_ack_i) |=> req_o);
  // R6: a clear with no competing edge empties the flag
  assert_req_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_clr_i && !hit_i) |=> !req_o);
  // R7: a disable command always wins
  assert_mie_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mie_clr_i |=> !mie_o);
  // R9: an acknowledge drops the master enable and the flag
  assert_ack_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack_i && !hit_i) |=> (!mie_o && !req_o));
endmodule

// File: rtl/extint_edge_unit.sv
module extint_edge_unit
  import extint_pkg::*;
#(
  parameter int FAST_DIV    = 4,
  parameter int SLOW_DIV    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic       mode_wr_i,
  input  logic [2:0] mode_wdata_i,
  input  logic       req_clr_i,
  input  logic       mie_set_i,
  input  logic       mie_clr_i,
  input  logic       src_en_i,
  input  logic       irq_ack_i,
  output logic       req_o,
  output logic       mie_o,
  output logic       irq_o
);
  localparam int NUM_RATES = 2;
  localparam int RATE_DIV [NUM_RATES] = '{FAST_DIV, SLOW_DIV};

  mode_t                mode_q;
  logic [NUM_RATES-1:0] tick;
  logic                 stb;
  logic                 hit;

  always_ff @(posedge clk) begin
    if (!rst_n)         mode_q <= MODE_RESET;
    else if (mode_wr_i) mode_q <= mode_t'(mode_wdata_i);
  end

  generate
    for (genvar r = 0; r < NUM_RATES; r++) begin : g_rate
      extint_tick_div #(.DIV(RATE_DIV[r])) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick[r])
      );
    end
  endgenerate

  assign stb = mode_q.slow ? tick[1] : tick[0];

  extint_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (pin_i),
    .stb_i (stb),
    .sel_i (mode_q.sel),
    .hit_o (hit)
  );

  extint_req_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_i     (hit),
    .req_clr_i (req_clr_i),
    .mie_set_i (mie_set_i),
    .mie_clr_i (mie_clr_i),
    .irq_ack_i (irq_ack_i),
    .req_o     (req_o),
    .mie_o     (mie_o)
  );

  assign irq_o = req_o & src_en_i & mie_o;

  // R5: the "none" edge code never raises the flag
  assert_none_no_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> ($past(mode_q.sel) != EDGE_NONE));
endmodule

// File: tb/test_extint_edge_unit.sv
module test_extint_edge_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_i = 1'b0;
  logic       mode_wr_i = 1'b0;
  logic [2:0] mode_wdata_i = 3'd0;
  logic       req_clr_i = 1'b0;
  logic       mie_set_i = 1'b0;
  logic       mie_clr_i = 1'b0;
  logic       src_en_i = 1'b0;
  logic       irq_ack_i = 1'b0;
  logic       req_o, mie_o, irq_o;

  int  errors = 0;
  int  checks = 0;
  bit  done = 1'b0;
  int  ecnt = 0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;
  end

  extint_edge_unit i_extint_edge_unit (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .mode_wr_i(mode_wr_i),
    .mode_wdata_i(mode_wdata_i), .req_clr_i(req_clr_i), .mie_set_i(mie_set_i),
    .mie_clr_i(mie_clr_i), .src_en_i(src_en_i), .irq_ack_i(irq_ack_i),
    .req_o(req_o), .mie_o(mie_o), .irq_o(irq_o)
  );

  // {mode[2:0], pin_from, pin_to, expected flag}
  localparam logic [5:0] VEC [16] = '{
    {3'b000, 1'b0, 1'b1, 1'b1}, {3'b000, 1'b1, 1'b0, 1'b0},
    {3'b001, 1'b0, 1'b1, 1'b0}, {3'b001, 1'b1, 1'b0, 1'b1},
    {3'b010, 1'b0, 1'b1, 1'b1}, {3'b010, 1'b1, 1'b0, 1'b1},
    {3'b011, 1'b0, 1'b1, 1'b0}, {3'b011, 1'b1, 1'b0, 1'b0},
    {3'b100, 1'b0, 1'b1, 1'b1}, {3'b100, 1'b1, 1'b0, 1'b0},
    {3'b101, 1'b0, 1'b1, 1'b0}, {3'b101, 1'b1, 1'b0, 1'b1},
    {3'b110, 1'b0, 1'b1, 1'b1}, {3'b110, 1'b1, 1'b0, 1'b1},
    {3'b111, 1'b0, 1'b1, 1'b0}, {3'b111, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_mode(input logic [2:0] m);
    mode_wdata_i = m; mode_wr_i = 1'b1;
    cyc(1);
    mode_wr_i = 1'b0;
  endtask

  task automatic pulse_clr();
    req_clr_i = 1'b1;
    cyc(1);
    req_clr_i = 1'b0;
  endtask

  task automatic align_slow();
    while (ecnt % 64 != 1) cyc(1);
  endtask

  initial begin
    cyc(5);
    // R1: reset state
    chk("R1 req after reset", req_o, 1'b0);
    chk("R1 mie after reset", mie_o, 1'b0);
    chk("R1 irq after reset", irq_o, 1'b0);
    rst_n = 1'b1;
    cyc(3);
    chk("R1 req idle", req_o, 1'b0);
    pin_i = 1'b1;
    cyc(20);
    chk("R1 default rising fast", req_o, 1'b1);

    // R6: explicit clear
    pulse_clr();
    chk("R6 clear", req_o, 1'b0);

    // R2 R3 R5: vector table
    for (int i = 0; i < 16; i++) begin
      write_mode(VEC[i][5:3]);
      pin_i = VEC[i][2];
      cyc(200);
      pulse_clr();
      cyc(2);
      chk("R2 flag cleared before step", req_o, 1'b0);
      pin_i = VEC[i][1];
      cyc(200);
      if (VEC[i][4:3] == 2'b11) chk("R5 none code", req_o, VEC[i][0]);
      else if (VEC[i][5])       chk("R3 slow sampling edge", req_o, VEC[i][0]);
      else                      chk("R2 fast sampling edge", req_o, VEC[i][0]);
    end

    // R4: short pulse between slow samples is rejected
    write_mode(3'b100);
    pin_i = 1'b0;
    cyc(200);
    pulse_clr();
    align_slow();
    pin_i = 1'b1;
    cyc(16);
    pin_i = 1'b0;
    cyc(150);
    chk("R4 slow rejects short pulse", req_o, 1'b0);

    // R3: same pulse is seen with fast sampling
    write_mode(3'b000);
    cyc(40);
    pulse_clr();
    align_slow();
    pin_i = 1'b1;
    cyc(16);
    pin_i = 1'b0;
    cyc(20);
    chk("R3 fast catches pulse", req_o, 1'b1);

    // R6 R8: flag sticky, irq gated by both enables
    chk("R8 irq low without enables", irq_o, 1'b0);
    src_en_i = 1'b1;
    cyc(1);
    chk("R8 irq low without master", irq_o, 1'b0);
    mie_set_i = 1'b1;
    cyc(1);
    mie_set_i = 1'b0;
    chk("R7 mie set", mie_o, 1'b1);
    chk("R8 irq high", irq_o, 1'b1);
    src_en_i = 1'b0;
    cyc(1);
    chk("R8 irq low with source off", irq_o, 1'b0);
    chk("R6 flag sticky", req_o, 1'b1);
    mie_clr_i = 1'b1;
    cyc(1);
    mie_clr_i = 1'b0;
    chk("R7 mie clear", mie_o, 1'b0);
    chk("R6 flag sticky after disable", req_o, 1'b1);

    // R7: clear wins over set
    mie_set_i = 1'b1; mie_clr_i = 1'b1;
    cyc(1);
    mie_set_i = 1'b0; mie_clr_i = 1'b0;
    chk("R7 clear wins", mie_o, 1'b0);

    // R9: acknowledge
    mie_set_i = 1'b1;
    cyc(1);
    mie_set_i = 1'b0;
    src_en_i = 1'b1;
    irq_ack_i = 1'b1;
    cyc(1);
    irq_ack_i = 1'b0;
    chk("R9 ack clears flag", req_o, 1'b0);
    chk("R9 ack clears mie", mie_o, 1'b0);
    chk("R8 irq low after ack", irq_o, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule